// File: doc/BRIEF.md
# Byte-Wide Memory Bus with Clock Register Overlay

This block is the bus front end of a battery-backed timekeeping memory. It sits behind a byte-wide, asynchronous-style bus with active-low chip enable, output enable and write enable, a 15-bit address and an 8-bit data bus. The asynchronous protocol is modelled with synchronous logic: the pins are sampled on the rising edge of the block clock. The block decodes the bus mode. It splits the address space into general storage and a 16-byte register window at the top, and it drives the data-bus output enable.

The top sixteen addresses, 7FF0h to 7FFFh, reach a register file that holds the clock, alarm, watchdog and control bytes. Every lower address reaches byte storage. A digital power-fail flag stands in for supply sensing. While the flag is high, the device is deselected and all writes are locked out. All contents are kept, so they can be read again after the flag clears.

Top module: `bytebus_rtc_mem`

## Requirements
- R1: While `ce_n` is 1, `dq_oe` is 0 and no write takes effect, whatever the levels on `oe_n` and `we_n`.
- R2: With `ce_n`=0, `we_n`=1 and `oe_n`=0 (and `pwr_fail`=0), `dq_oe` is 1 in the same cycle and `dq_out` carries the byte stored at `addr`.
- R3: With `ce_n`=0, `we_n`=1 and `oe_n`=1, `dq_oe` is 0. Whenever `dq_oe` is 0, `dq_out` is 00h.
- R4: With `ce_n`=0 and `we_n`=0 at a rising clock edge, `dq_in` is stored at `addr`, whatever the level of `oe_n`. During such a write `dq_oe` is 0.
- R5: Addresses 7FF0h to 7FFFh select a 16-byte register file indexed by `addr[3:0]`. Writes there leave storage unchanged, and writes to storage leave the registers unchanged.
- R6: Storage holds 2**STORE_AW bytes (STORE_AW defaults to 10). An address below 7FF0h selects the storage byte `addr[STORE_AW-1:0]`, so addresses that differ only above bit STORE_AW-1 select the same byte.
- R7: While `pwr_fail` is 1, `dq_oe` is 0 and no write takes effect, whatever the control pins do.
- R8: Storage and register contents are kept through a `pwr_fail` period and read back unchanged once it clears.
- R9: A synchronous active-high `rst` clears all 16 registers to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; bus pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pwr_fail | input | 1 | Supply out-of-tolerance flag, active high |
| addr | input | 15 | Byte address |
| dq_in | input | 8 | Data bus, input side |
| dq_out | output | 8 | Data bus, output side (00h when not driving) |
| dq_oe | output | 1 | Data bus output enable for the pad driver |

## Verification
The hardest case to reach from the ports is a storage byte and a register that share their low address bits. A write to one must leave the other alone, and that must stay true across a power-fail window in which write attempts are made and then cleared. Directed cases first set up such an aliasing pair: a storage byte at 03F3h and the register at 7FF3h. They then attempt writes under the power-fail flag and read both locations back once it drops. After that, a seeded random run mixes every pin combination with the flag. Its addresses are biased toward the register window and toward a narrow storage range, so that overwrites and aliases happen often. A reference model of storage and registers in the bench checks each cycle.

// File: rtl/bytebus_pkg.sv
package bytebus_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;
    localparam int REG_AW = 4;
    localparam int NUM_REGS = 1 << REG_AW;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic              reg_hit;
        logic [REG_AW-1:0] reg_idx;
    } region_t;

    // Write enable outranks output enable; power fail and chip enable deselect.
    function automatic bus_mode_e decode_mode(
        input logic ce_n,
        input logic oe_n,
        input logic we_n,
        input logic pfail
    );
        if (pfail || ce_n) return BUS_IDLE;
        if (!we_n)         return BUS_WRITE;
        if (!oe_n)         return BUS_READ;
        return BUS_IDLE;
    endfunction

endpackage

// File: rtl/bb_mode_decode.sv
module bb_mode_decode
    import bytebus_pkg::*;
(
    input  logic      rst,
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      we_n,
    input  logic      pfail,
    output bus_mode_e mode_o
);
    always_comb begin
        if (rst) mode_o = BUS_IDLE;
        else     mode_o = decode_mode(ce_n, oe_n, we_n, pfail);
    end
endmodule

// File: rtl/bb_region_decode.sv
module bb_region_decode
    import bytebus_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    output region_t       region_o
);
    always_comb begin
        region_o.reg_hit = &addr_i[AW-1:REG_AW];
        region_o.reg_idx = addr_i[REG_AW-1:0];
    end
endmodule

// File: rtl/bb_byte_store.sv
module bb_byte_store #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[idx_i] <= wdata_i;
    end

    assign rdata_o = mem[idx_i];

    assert_store_write_R4: assert property (@(posedge clk) disable iff (rst)
        we_i |=> mem[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/bb_reg_file.sv
module bb_reg_file
    import bytebus_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [REG_AW-1:0] idx_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o
);
    logic [NUM_REGS-1:0][DW-1:0] regs_q;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)                              regs_q[g] <= '0;
                else if (we_i && idx_i == REG_AW'(g)) regs_q[g] <= wdata_i;
            end
        end
    endgenerate

    assign rdata_o = regs_q[idx_i];

    assert_reg_write_R5: assert property (@(posedge clk) disable iff (rst)
        we_i |=> regs_q[$past(idx_i)] == $past(wdata_i));

    assert_reg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(regs_q));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> regs_q == '0);
endmodule

// File: rtl/bytebus_rtc_mem.sv
module bytebus_rtc_mem
    import bytebus_pkg::*;
#(
    parameter int STORE_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              pwr_fail,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    bus_mode_e         mode;
    region_t           region;
    logic              store_we;
    logic              reg_we;
    logic [DATA_W-1:0] store_rd;
    logic [DATA_W-1:0] reg_rd;

    bb_mode_decode u_mode (
        .rst    (rst),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .pfail  (pwr_fail),
        .mode_o (mode)
    );

    bb_region_decode #(.AW(ADDR_W)) u_region (
        .addr_i   (addr),
        .region_o (region)
    );

    assign store_we = (mode == BUS_WRITE) && !region.reg_hit;
    assign reg_we   = (mode == BUS_WRITE) &&  region.reg_hit;

    bb_byte_store #(.AW(STORE_AW), .DW(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (store_we),
        .idx_i   (addr[STORE_AW-1:0]),
        .wdata_i (dq_in),
        .rdata_o (store_rd)
    );

    bb_reg_file #(.DW(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we_i    (reg_we),
        .idx_i   (region.reg_idx),
        .wdata_i (dq_in),
        .rdata_o (reg_rd)
    );

    always_comb begin
        dq_oe  = (mode == BUS_READ);
        dq_out = '0;
        if (dq_oe) dq_out = region.reg_hit ? reg_rd : store_rd;
    end

    assert_deselect_R1: assert property (@(posedge clk) disable iff (rst)
        ce_n |-> !dq_oe && !store_we && !reg_we);

    assert_quiet_bus_R3: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> dq_out == '0);

    assert_wr_priority_R4: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !dq_oe);

    assert_region_split_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_we, reg_we}));

    assert_lockout_R7: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |-> !dq_oe && !store_we && !reg_we);
endmodule

// File: tb/bytebus_rtc_mem_tb_top.sv
module bytebus_rtc_mem_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SAW = 10;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pwr_fail = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  dq_in = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] ref_store [1 << SAW];
    bit         ref_valid [1 << SAW];
    logic [7:0] ref_regs  [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    bytebus_rtc_mem #(.STORE_AW(SAW)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .pwr_fail(pwr_fail), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic bit is_reg(input logic [14:0] a);
        return a >= 15'h7FF0;
    endfunction

    function automatic bit exp_drive(input bit c, input bit o, input bit w, input bit p);
        return !p && !c && w && !o;
    endfunction

    function automatic bit exp_write(input bit c, input bit w, input bit p);
        return !p && !c && !w;
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at negedge, check outputs, let the edge act, update model.
    task automatic bus_op(input string req, input bit c, input bit o, input bit w,
                          input bit p, input logic [14:0] a, input logic [7:0] d);
        bit drive;
        @(negedge clk);
        ce_n = c; oe_n = o; we_n = w; pwr_fail = p; addr = a; dq_in = d;
        #1;
        drive = exp_drive(c, o, w, p);
        check(req, "dq_oe", {7'd0, dq_oe}, {7'd0, drive});
        if (!drive) begin
            check(req, "dq_out idle", dq_out, 8'h00);
        end else if (is_reg(a)) begin
            check(req, "reg read", dq_out, ref_regs[a[3:0]]);
        end else if (ref_valid[a[SAW-1:0]]) begin
            check(req, "store read", dq_out, ref_store[a[SAW-1:0]]);
        end
        @(posedge clk);
        if (exp_write(c, w, p)) begin
            if (is_reg(a)) ref_regs[a[3:0]] = d;
            else begin
                ref_store[a[SAW-1:0]] = d;
                ref_valid[a[SAW-1:0]] = 1'b1;
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ce_n = 1'b1; pwr_fail = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) ref_regs[i] = 8'h00;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < (1 << SAW); i++) ref_valid[i] = 1'b0;
        do_reset();

        // R9: registers read zero after reset
        for (int i = 0; i < 16; i++) bus_op("R9", 0, 0, 1, 0, 15'h7FF0 + 15'(i), 8'h00);

        // R4 / R2: write with oe low, then read back
        bus_op("R4", 0, 0, 0, 0, 15'h0005, 8'hA5);
        bus_op("R2", 0, 0, 1, 0, 15'h0005, 8'h00);
        // R6: alias above bit 9
        bus_op("R6", 0, 0, 1, 0, 15'h0405, 8'h00);
        bus_op("R6", 0, 1, 0, 0, 15'h4C05, 8'h5A);
        bus_op("R6", 0, 0, 1, 0, 15'h0005, 8'h00);
        // R3: output enable high, no drive
        bus_op("R3", 0, 1, 1, 0, 15'h0005, 8'h00);
        // R5: storage 03F3h and register 7FF3h share low bits
        bus_op("R5", 0, 1, 0, 0, 15'h03F3, 8'h11);
        bus_op("R5", 0, 1, 0, 0, 15'h7FF3, 8'h3C);
        bus_op("R5", 0, 0, 1, 0, 15'h03F3, 8'h00);
        bus_op("R5", 0, 0, 1, 0, 15'h7FF3, 8'h00);
        // R1: deselected write is ignored, checked by read-back
        bus_op("R1", 1, 0, 0, 0, 15'h7FF3, 8'hEE);
        bus_op("R1", 1, 0, 0, 0, 15'h03F3, 8'hEE);
        bus_op("R1", 0, 0, 1, 0, 15'h7FF3, 8'h00);
        bus_op("R1", 0, 0, 1, 0, 15'h03F3, 8'h00);
        // R7: power fail blocks writes and reads
        bus_op("R7", 0, 0, 1, 1, 15'h03F3, 8'h00);
        bus_op("R7", 0, 1, 0, 1, 15'h03F3, 8'h99);
        bus_op("R7", 0, 1, 0, 1, 15'h7FF3, 8'h99);
        // R8: contents intact after the flag clears
        bus_op("R8", 0, 0, 1, 0, 15'h03F3, 8'h00);
        bus_op("R8", 0, 0, 1, 0, 15'h7FF3, 8'h00);
        bus_op("R8", 0, 0, 1, 0, 15'h0005, 8'h00);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            bit c, o, w, p;
            logic [14:0] a;
            string req;
            int sel;
            c = ($urandom % 6) == 0;
            o = $urandom % 2;
            w = $urandom % 2;
            p = ($urandom % 8) == 0;
            sel = $urandom % 4;
            if (sel == 0)      a = 15'h7FF0 + 15'($urandom % 16);
            else if (sel == 1) a = 15'($urandom % 32) | (15'($urandom % 31) << SAW);
            else               a = 15'($urandom);
            if (p)           req = "R7";
            else if (c)      req = "R1";
            else if (!w)     req = "R4";
            else if (o)      req = "R3";
            else if (is_reg(a)) req = "R5";
            else             req = "R2";
            bus_op(req, c, o, w, p, a, 8'($urandom));
        end

        // R8: sweep the register window after the random run
        for (int i = 0; i < 16; i++) bus_op("R8", 0, 0, 1, 0, 15'h7FF0 + 15'(i), 8'h00);

        // R9: reset again mid-run
        do_reset();
        for (int i = 0; i < 16; i++) bus_op("R9", 0, 0, 1, 0, 15'h7FF0 + 15'(i), 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule